// File: doc/BRIEF.md
# Single-Wire Humidity Sensor Responder

This block acts as the sensor end of a one-wire temperature and humidity link. The data line is open-drain and is pulled up externally. The block can only pull the line low, through its `drive_low` output, and it reads the line back through `line_in`.

While idle, the block waits for a host start request. A start request is a long low pulse followed by a release. When the low pulse is long enough, the block copies its four input data bytes. It then sends a response preamble, followed by a 40-bit frame. The frame holds the four bytes and an 8-bit checksum. Each bit is sent as a fixed low period and then a high period, and the length of the high period gives the bit value.

Every duration is counted in microseconds. A divider built from the clock-frequency parameter produces the microsecond timebase, and that timebase is also available on an output. The `busy` output covers the whole exchange. The `done` output pulses once when the exchange ends.

Top module: `rh_line_responder`

## Requirements
- R1: After reset, `drive_low`, `busy` and `done` are all 0.
- R2: A start is accepted when the synchronised line has been low for more than START_MIN_US microseconds and then returns high. `busy` rises, and `drive_low` first asserts TURN_US microseconds (TURN_US*DIV cycles, plus the synchroniser and edge-detect delay of at most 6 cycles) after the release.
- R3: A low pulse shorter than START_MIN_US microseconds, followed by a release, leaves the block idle. `busy` and `drive_low` stay 0.
- R4: The response preamble is `drive_low` held for exactly ACK_LOW_US*DIV cycles and then released for exactly ACK_HIGH_US*DIV cycles, where DIV = CLK_HZ/1_000_000.
- R5: Every data bit begins with `drive_low` held for exactly BIT_LOW_US*DIV cycles.
- R6: A 0 bit is followed by a release of exactly ZERO_HIGH_US*DIV cycles. A 1 bit is followed by a release of exactly ONE_HIGH_US*DIV cycles.
- R7: The 40 bits are sent in this order: `hum_int`, `hum_frac`, `temp_int`, `temp_frac`, then the checksum. Each byte is sent most significant bit first.
- R8: The checksum byte is (hum_int + hum_frac + temp_int + temp_frac) mod 256.
- R9: After the last bit, `drive_low` is held for BIT_LOW_US*DIV cycles and then released for good. In the first released cycle, `done` is 1 and `busy` is 0. `done` is 0 again in the next cycle.
- R10: The data bytes are captured when the start is accepted. Changes to the byte inputs during the exchange do not affect the frame being sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, CLK_HZ |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_in | input | 1 | Level read back from the shared data line |
| drive_low | output | 1 | 1 pulls the line low; 0 releases it to the pull-up |
| hum_int | input | 8 | Humidity, integer byte |
| hum_frac | input | 8 | Humidity, fraction byte |
| temp_int | input | 8 | Temperature, integer byte |
| temp_frac | input | 8 | Temperature, fraction byte |
| us_tick | output | 1 | One-cycle pulse at each microsecond boundary of the active timer |
| busy | output | 1 | High from an accepted start until the frame ends |
| done | output | 1 | One-cycle pulse when the line is released after the frame |

## Verification
The hardest case to reach is the edge of start qualification. A host low pulse just under the threshold must be dropped, and one just over it must be accepted. The off-by-one between the synchroniser, the falling-edge timer restart and the tick count decides the outcome. The stimulus drives pulses of (START_MIN_US-2) and (START_MIN_US+2) microseconds, counted in clock cycles, and follows each with a release. The bench models the wired line as the AND of host and device. It decodes every frame from the measured pulse widths alone, and it changes the byte inputs partway through one frame to show that the captured copy is the one sent.

// File: rtl/rhl_pkg.sv
package rhl_pkg;
   localparam int BYTE_W      = 8;
   localparam int DATA_BYTES  = 4;
   localparam int FRAME_BYTES = DATA_BYTES + 1;
   localparam int FRAME_W     = FRAME_BYTES * BYTE_W;

   typedef enum logic [2:0] {
      PH_IDLE   = 3'd0,
      PH_TURN   = 3'd1,
      PH_ACK_LO = 3'd2,
      PH_ACK_HI = 3'd3,
      PH_BIT_LO = 3'd4,
      PH_BIT_HI = 3'd5,
      PH_TAIL   = 3'd6
   } phase_t;
endpackage

// File: rtl/rhl_us_tick.sv
module rhl_us_tick #(
   parameter int DIV = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr,
   output logic tick
);
   generate
      if (DIV == 1) begin : g_direct
         logic unused_clr;
         assign unused_clr = clr;
         assign tick = 1'b1;
      end else begin : g_div
         localparam int CW = $clog2(DIV);
         localparam logic [CW-1:0] LAST = CW'(DIV - 1);
         logic [CW-1:0] cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt <= '0;
            else if (clr)         cnt <= '0;
            else if (cnt == LAST) cnt <= '0;
            else                  cnt <= cnt + CW'(1);
         end
         assign tick = (cnt == LAST);
      end
   endgenerate
endmodule

// File: rtl/rhl_start_qual.sv
module rhl_start_qual #(
   parameter int MIN_US = 18000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic en,
   input  logic line_s,
   input  logic tick,
   output logic fall,
   output logic start
);
   localparam int CW = $clog2(MIN_US + 1);
   localparam logic [CW-1:0] MIN_V = CW'(MIN_US);

   logic          line_d;
   logic          rise;
   logic [CW-1:0] low_us;

   assign fall  = en & line_d & ~line_s;
   assign rise  = ~line_d & line_s;
   assign start = en & rise & (low_us == MIN_V);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         line_d <= 1'b1;
         low_us <= '0;
      end else begin
         line_d <= line_s;
         if (!en || fall || rise)
            low_us <= '0;
         else if (!line_s && tick && low_us != MIN_V)
            low_us <= low_us + CW'(1);
      end
   end
endmodule

// File: rtl/rhl_checksum.sv
module rhl_checksum
   import rhl_pkg::*;
(
   input  logic [DATA_BYTES*BYTE_W-1:0] bytes_in,
   output logic [FRAME_W-1:0]           frame
);
   logic [BYTE_W-1:0] part [DATA_BYTES+1];

   assign part[0] = '0;
   generate
      for (genvar i = 0; i < DATA_BYTES; i++) begin : g_add
         assign part[i+1] = part[i] + bytes_in[(DATA_BYTES-1-i)*BYTE_W +: BYTE_W];
      end
   endgenerate

   assign frame = {bytes_in, part[DATA_BYTES]};
endmodule

// File: rtl/rhl_frame_tx.sv
module rhl_frame_tx
   import rhl_pkg::*;
#(
   parameter int TURN_US      = 30,
   parameter int ACK_LOW_US   = 80,
   parameter int ACK_HIGH_US  = 80,
   parameter int BIT_LOW_US   = 50,
   parameter int ZERO_HIGH_US = 25,
   parameter int ONE_HIGH_US  = 80
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               start,
   input  logic               tick,
   input  logic [FRAME_W-1:0] frame,
   output logic               adv,
   output logic               drive_low,
   output logic               busy,
   output logic               done
);
   localparam int M1     = (TURN_US > ACK_LOW_US) ? TURN_US : ACK_LOW_US;
   localparam int M2     = (ACK_HIGH_US > BIT_LOW_US) ? ACK_HIGH_US : BIT_LOW_US;
   localparam int M3     = (ZERO_HIGH_US > ONE_HIGH_US) ? ZERO_HIGH_US : ONE_HIGH_US;
   localparam int M12    = (M1 > M2) ? M1 : M2;
   localparam int MAX_US = (M12 > M3) ? M12 : M3;
   localparam int US_W   = $clog2(MAX_US + 1);
   localparam int IDX_W  = $clog2(FRAME_W);
   localparam logic [IDX_W-1:0] LAST_BIT = IDX_W'(FRAME_W - 1);

   phase_t            phase;
   logic [US_W-1:0]   us_cnt;
   logic [US_W-1:0]   dur_m1;
   logic [IDX_W-1:0]  bit_idx;
   logic [FRAME_W-1:0] shreg;

   always_comb begin
      unique case (phase)
         PH_TURN:   dur_m1 = US_W'(TURN_US - 1);
         PH_ACK_LO: dur_m1 = US_W'(ACK_LOW_US - 1);
         PH_ACK_HI: dur_m1 = US_W'(ACK_HIGH_US - 1);
         PH_BIT_LO: dur_m1 = US_W'(BIT_LOW_US - 1);
         PH_TAIL:   dur_m1 = US_W'(BIT_LOW_US - 1);
         PH_BIT_HI: dur_m1 = shreg[FRAME_W-1] ? US_W'(ONE_HIGH_US - 1)
                                              : US_W'(ZERO_HIGH_US - 1);
         default:   dur_m1 = '0;
      endcase
   end

   assign adv       = (phase != PH_IDLE) && tick && (us_cnt == dur_m1);
   assign busy      = (phase != PH_IDLE);
   assign drive_low = (phase == PH_ACK_LO) || (phase == PH_BIT_LO) || (phase == PH_TAIL);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase   <= PH_IDLE;
         us_cnt  <= '0;
         bit_idx <= '0;
         shreg   <= '0;
         done    <= 1'b0;
      end else begin
         done <= adv && (phase == PH_TAIL);
         if (start && phase == PH_IDLE) begin
            phase   <= PH_TURN;
            us_cnt  <= '0;
            bit_idx <= '0;
         end else if (adv) begin
            us_cnt <= '0;
            unique case (phase)
               PH_TURN: begin
                  phase <= PH_ACK_LO;
                  shreg <= frame;
               end
               PH_ACK_LO: phase <= PH_ACK_HI;
               PH_ACK_HI: phase <= PH_BIT_LO;
               PH_BIT_LO: phase <= PH_BIT_HI;
               PH_BIT_HI: begin
                  shreg <= {shreg[FRAME_W-2:0], 1'b0};
                  if (bit_idx == LAST_BIT) begin
                     phase <= PH_TAIL;
                  end else begin
                     bit_idx <= bit_idx + IDX_W'(1);
                     phase   <= PH_BIT_LO;
                  end
               end
               default: phase <= PH_IDLE;
            endcase
         end else if (tick && phase != PH_IDLE) begin
            us_cnt <= us_cnt + US_W'(1);
         end
      end
   end
endmodule

// File: rtl/rh_line_responder.sv
module rh_line_responder
   import rhl_pkg::*;
#(
   parameter int CLK_HZ       = 50_000_000,
   parameter int SYNC_STAGES  = 2,
   parameter int START_MIN_US = 18000,
   parameter int TURN_US      = 30,
   parameter int ACK_LOW_US   = 80,
   parameter int ACK_HIGH_US  = 80,
   parameter int BIT_LOW_US   = 50,
   parameter int ZERO_HIGH_US = 25,
   parameter int ONE_HIGH_US  = 80
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       line_in,
   output logic       drive_low,
   input  logic [7:0] hum_int,
   input  logic [7:0] hum_frac,
   input  logic [7:0] temp_int,
   input  logic [7:0] temp_frac,
   output logic       us_tick,
   output logic       busy,
   output logic       done
);
   localparam int DIV = CLK_HZ / 1_000_000;

   generate
      if (CLK_HZ < 1_000_000 || (CLK_HZ % 1_000_000) != 0) begin : g_bad_clk
         $error("CLK_HZ must be a whole multiple of 1 MHz");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (ONE_HIGH_US <= ZERO_HIGH_US) begin : g_bad_bits
         $error("ONE_HIGH_US must exceed ZERO_HIGH_US");
      end
      if (TURN_US < 1 || ACK_LOW_US < 1 || ACK_HIGH_US < 1 ||
          BIT_LOW_US < 1 || ZERO_HIGH_US < 1 || START_MIN_US < 1) begin : g_bad_dur
         $error("all durations must be at least 1 us");
      end
   endgenerate

   logic [SYNC_STAGES-1:0] sync_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) sync_q <= '1;
      else        sync_q <= {sync_q[SYNC_STAGES-2:0], line_in};
   end
   logic line_s;
   assign line_s = sync_q[SYNC_STAGES-1];

   logic tick, tick_clr, fall, start, adv;
   assign tick_clr = fall | start | adv;
   assign us_tick  = tick;

   rhl_us_tick #(.DIV(DIV)) u_tick (
      .clk(clk), .rst_n(rst_n), .clr(tick_clr), .tick(tick)
   );

   rhl_start_qual #(.MIN_US(START_MIN_US)) u_qual (
      .clk(clk), .rst_n(rst_n), .en(~busy), .line_s(line_s),
      .tick(tick), .fall(fall), .start(start)
   );

   logic [DATA_BYTES*BYTE_W-1:0] cap_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     cap_q <= '0;
      else if (start) cap_q <= {hum_int, hum_frac, temp_int, temp_frac};
   end

   logic [FRAME_W-1:0] frame;
   rhl_checksum u_sum (.bytes_in(cap_q), .frame(frame));

   rhl_frame_tx #(
      .TURN_US(TURN_US), .ACK_LOW_US(ACK_LOW_US), .ACK_HIGH_US(ACK_HIGH_US),
      .BIT_LOW_US(BIT_LOW_US), .ZERO_HIGH_US(ZERO_HIGH_US), .ONE_HIGH_US(ONE_HIGH_US)
   ) u_tx (
      .clk(clk), .rst_n(rst_n), .start(start), .tick(tick), .frame(frame),
      .adv(adv), .drive_low(drive_low), .busy(busy), .done(done)
   );
endmodule

// File: rtl/rhl_checker.sv
module rhl_checker #(
   parameter int ACK_LO_CYC = 160,
   parameter int BIT_LO_CYC = 100
) (
   input logic        clk,
   input logic        rst_n,
   input logic        line_in,
   input logic        drive_low,
   input logic        busy,
   input logic        done,
   input logic [31:0] cap_q
);
   int unsigned lo_run;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         lo_run <= 0;
      else if (drive_low) lo_run <= lo_run + 1;
      else                lo_run <= 0;
   end

   p_idle_released_r1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> !drive_low);

   p_start_after_release_r2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> line_in);

   p_low_width_r5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(drive_low) |-> (lo_run == ACK_LO_CYC || lo_run == BIT_LO_CYC));

   p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   p_done_ends_busy_r9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!busy && $past(busy)));

   p_capture_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy)) |-> $stable(cap_q));
endmodule

bind rh_line_responder rhl_checker #(
   .ACK_LO_CYC(ACK_LOW_US * DIV),
   .BIT_LO_CYC(BIT_LOW_US * DIV)
) u_chk (
   .clk(clk), .rst_n(rst_n), .line_in(line_in), .drive_low(drive_low),
   .busy(busy), .done(done), .cap_q(cap_q)
);

// File: tb/sim_rh_line_responder.sv
module sim_rh_line_responder;
   localparam int CLK_PERIOD = 10;
   localparam int CLK_HZ     = 2_000_000;
   localparam int DIV        = CLK_HZ / 1_000_000;
   localparam int START_US   = 200;
   localparam int TURN_US    = 30;
   localparam int ACK_LO     = 80 * DIV;
   localparam int ACK_HI     = 80 * DIV;
   localparam int BIT_LO     = 50 * DIV;
   localparam int ZERO_HI    = 25 * DIV;
   localparam int ONE_HI     = 80 * DIV;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic host_low = 1'b0;
   logic [7:0] b_hi = 8'h00, b_hf = 8'h00, b_ti = 8'h00, b_tf = 8'h00;
   logic drive_low, us_tick, busy, done;
   logic line;

   assign line = ~(host_low | drive_low);

   always #(CLK_PERIOD/2) clk = ~clk;

   rh_line_responder #(
      .CLK_HZ(CLK_HZ), .START_MIN_US(START_US), .TURN_US(TURN_US)
   ) u0 (
      .clk(clk), .rst_n(rst_n), .line_in(line), .drive_low(drive_low),
      .hum_int(b_hi), .hum_frac(b_hf), .temp_int(b_ti), .temp_frac(b_tf),
      .us_tick(us_tick), .busy(busy), .done(done)
   );

   int total = 0;
   int bad   = 0;
   bit finished = 1'b0;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic level_len(input logic lvl, output int n);
      n = 0;
      while (drive_low == lvl && n < 100000) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic host_pulse(input int cycles);
      host_low = 1'b1;
      repeat (cycles) @(negedge clk);
      host_low = 1'b0;
   endtask

   task automatic run_frame(input logic [7:0] h1, h2, t1, t2, input bit disturb);
      logic [39:0] got;
      logic [39:0] exp;
      logic [7:0]  sum;
      int n, turn;
      sum = h1 + h2 + t1 + t2;
      exp = {h1, h2, t1, t2, sum};
      got = '0;
      b_hi = h1; b_hf = h2; b_ti = t1; b_tf = t2;
      @(negedge clk);
      host_pulse((START_US + 2) * DIV);
      turn = 0;
      while (!drive_low && turn < 5000) begin
         turn++;
         @(negedge clk);
      end
      check(busy === 1'b1, "R2 busy on accepted start", busy, 1);
      check(turn >= TURN_US * DIV && turn <= TURN_US * DIV + 6,
            "R2 turnaround cycles", turn, TURN_US * DIV);
      level_len(1'b1, n);
      check(n == ACK_LO, "R4 ack low", n, ACK_LO);
      level_len(1'b0, n);
      check(n == ACK_HI, "R4 ack high", n, ACK_HI);
      if (disturb) begin
         b_hi = ~h1; b_hf = h2 + 8'd7; b_ti = ~t1; b_tf = t2 ^ 8'h5A;
      end
      for (int b = 0; b < 40; b++) begin
         level_len(1'b1, n);
         if (n != BIT_LO) check(1'b0, "R5 bit low", n, BIT_LO);
         level_len(1'b0, n);
         if (n == ZERO_HI)     got = {got[38:0], 1'b0};
         else if (n == ONE_HI) got = {got[38:0], 1'b1};
         else begin
            check(1'b0, "R6 bit high width", n, ZERO_HI);
            got = {got[38:0], 1'b0};
         end
      end
      check(1'b1, "R5 R6 bit widths", 0, 0);
      // tail low already consumed as the final 'bit low'? no: last bit high ends at tail low
      level_len(1'b1, n);
      check(n == BIT_LO, "R9 trailing low", n, BIT_LO);
      check(done === 1'b1 && busy === 1'b0, "R9 done at release",
            {30'd0, done, busy}, 2);
      @(negedge clk);
      check(done === 1'b0 && drive_low === 1'b0, "R9 done single cycle",
            {30'd0, done, drive_low}, 0);
      check(got[39:8] == exp[39:8], disturb ? "R10 captured bytes sent" : "R7 data order",
            int'(got[39:8]), int'(exp[39:8]));
      check(got[7:0] == sum, "R8 checksum", got[7:0], sum);
      b_hi = h1; b_hf = h2; b_ti = t1; b_tf = t2;
      repeat (50) @(negedge clk);
   endtask

   initial begin
      repeat (CLK_PERIOD * 200000) @(posedge clk);
      if (!finished) begin
         finished = 1'b1;
         total++;
         bad++;
         $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      logic [31:0] lfsr;
      bit quiet;
      lfsr = 32'hACE1_2345;
      repeat (3) @(negedge clk);
      check(drive_low === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 reset state",
            {29'd0, drive_low, busy, done}, 0);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      check(drive_low === 1'b0 && busy === 1'b0 && done === 1'b0, "R1 idle after reset",
            {29'd0, drive_low, busy, done}, 0);

      // R3: pulse just under the threshold must be dropped
      host_pulse((START_US - 2) * DIV);
      quiet = 1'b1;
      repeat ((TURN_US + 200) * DIV) begin
         @(negedge clk);
         if (drive_low !== 1'b0 || busy !== 1'b0) quiet = 1'b0;
      end
      check(quiet, "R3 short low ignored", quiet, 1);
      host_pulse(DIV * 5);
      quiet = 1'b1;
      repeat ((TURN_US + 200) * DIV) begin
         @(negedge clk);
         if (drive_low !== 1'b0 || busy !== 1'b0) quiet = 1'b0;
      end
      check(quiet, "R3 glitch ignored", quiet, 1);

      run_frame(8'h00, 8'h00, 8'h00, 8'h00, 1'b0);
      run_frame(8'hFF, 8'hFF, 8'hFF, 8'hFF, 1'b0);
      run_frame(8'h80, 8'h01, 8'h55, 8'hAA, 1'b0);
      run_frame(8'h3C, 8'h09, 8'h17, 8'h04, 1'b1);
      for (int k = 0; k < 3; k++) begin
         lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
         lfsr = lfsr * 32'd1103515245 + 32'd12345;
         run_frame(lfsr[31:24], lfsr[23:16], lfsr[15:8], lfsr[7:0], k == 1);
      end

      if (!finished) begin
         finished = 1'b1;
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule